// File: doc/BRIEF.md
# Start-of-Frame and Byte Delimiter Strobe Generator

This block sits behind the Manchester decoder of a 10 Mbps Ethernet receiver. It watches the decoded bit stream, one bit per bit clock. It hunts for the start frame delimiter and then produces a delimiter strobe that an external address-matching circuit uses to find byte boundaries in the forwarded serial data.

The decoded bits are re-timed through one register and come out as `ser_out`. The strobe is timed to line up with that delayed stream. It rises in the same cycle that `ser_out` presents the first destination-address bit. It then forms a square wave of four bit times high and four bit times low, so every rising edge marks the first bit of a byte.

Detection is abandoned when receive-valid falls or when the local transmitter is active. In either case the detector has to see a complete new delimiter before it can fire again.

Top module: `sfd_delim_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `delim_strobe` and `ser_out` are 0 after that edge.
- R2: After every edge, `ser_out` equals `rx_bit & rx_valid` as sampled at that edge, which is one cycle of latency.
- R3: The delimiter is the 8-bit sequence 1,0,1,0,1,0,1,1 in arrival order. Sent least-significant bit first, this is the byte 0xD5, and the preamble byte 0x55 gives 1,0,1,0,1,0,1,0. If those 8 bits are sampled on consecutive edges with `rx_valid`=1 and `tx_busy`=0, and the last of them is sampled at edge k, then `delim_strobe` goes to 1 after edge k+1. That is the same cycle in which `ser_out` shows the bit sampled at edge k+1.
- R4: Once started, `delim_strobe` stays 1 for exactly 4 cycles and then alternates between 4 cycles at 0 and 4 cycles at 1. Each rising edge coincides with `ser_out` showing bit 8n (n = 0, 1, ...) of the data that follows the delimiter.
- R5: A bit stream with no exact delimiter match, such as a preamble alone or a delimiter with any single bit inverted, leaves `delim_strobe` at 0.
- R6: An edge that samples `rx_valid`=0 drives `delim_strobe` to 0 after that edge. It also clears the bit history, so a new full 8-bit delimiter is needed before the strobe can start again.
- R7: An edge that samples `tx_busy`=1 drives `delim_strobe` to 0 after that edge and clears the bit history in the same way, so no delimiter is detected across a transmission.
- R8: While the strobe is running, a delimiter pattern inside the data does not restart or shift its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one decoded bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Decoded receive data present |
| rx_bit | input | 1 | Decoded serial receive bit |
| tx_busy | input | 1 | Local transmitter active |
| delim_strobe | output | 1 | Start-of-frame and byte-boundary strobe |
| ser_out | output | 1 | Re-timed serial receive data |

## Verification
The forwarded bit is due one edge after it is sampled. The first strobe high is due one edge after the edge that sampled the closing 1 of the delimiter, and each later toggle is due four edges after the previous one. The bench drives every bit on the falling clock edge and compares both outputs 1 ns after the following rising edge, so every comparison sees the first cycle in which a result is due. The expected strobe comes from a bit-level model in the bench that counts edges from the delimiter. Abort, no-match and mid-data-pattern streams are checked in the same way, cycle by cycle.

// File: rtl/sfd_delim_pkg.sv
package sfd_delim_pkg;
  // delimiter as an 8-bit history word: oldest bit at the MSB, newest at the LSB
  localparam int unsigned    SFD_BITS = 8;
  localparam logic [7:0]     SFD_WORD = 8'b1010_1011;
  localparam int unsigned    HALF_BYTE_BITS = 4;

  typedef enum logic {
    PH_HUNT  = 1'b0,
    PH_TRACK = 1'b1
  } phase_state_e;
endpackage

// File: rtl/sfd_hunt.sv
module sfd_hunt #(
  parameter int unsigned    W   = 8,
  parameter logic [W-1:0]   PAT = 8'b1010_1011
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_ok,
  input  logic rx_bit,
  output logic found
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst || !rx_ok) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[W-2:0], rx_bit};
    end
  end

  assign found = (hist_q == PAT);

  // R6
  hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ok |=> !found);
endmodule

// File: rtl/delim_phase.sv
module delim_phase
  import sfd_delim_pkg::*;
#(
  parameter int unsigned HALF_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_ok,
  input  logic found,
  output logic strobe
);
  localparam int unsigned   CW   = (HALF_BITS > 2) ? $clog2(HALF_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_BITS - 1);

  phase_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic          strobe_q;

  always_ff @(posedge clk) begin
    if (rst || !rx_ok) begin
      state_q  <= PH_HUNT;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      case (state_q)
        PH_HUNT: begin
          if (found) begin
            state_q  <= PH_TRACK;
            cnt_q    <= '0;
            strobe_q <= 1'b1;
          end
        end
        default: begin
          if (cnt_q == LAST) begin
            cnt_q    <= '0;
            strobe_q <= ~strobe_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign strobe = strobe_q;

  // R4
  strobe_needs_track_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> state_q == PH_TRACK);

  // R4
  toggle_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_TRACK && !$stable(strobe_q)) |-> cnt_q == '0);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_TRACK && rx_ok && cnt_q != LAST) |=> $stable(strobe_q));
endmodule

// File: rtl/ser_fwd.sv
module ser_fwd (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic ser_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= 1'b0;
    end else begin
      ser_out <= rx_bit & rx_valid;
    end
  end
endmodule

// File: rtl/sfd_delim_gen.sv
module sfd_delim_gen
  import sfd_delim_pkg::*;
#(
  parameter int unsigned          PAT_BITS  = SFD_BITS,
  parameter logic [PAT_BITS-1:0]  PAT_WORD  = SFD_WORD,
  parameter int unsigned          HALF_BITS = HALF_BYTE_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_busy,
  output logic delim_strobe,
  output logic ser_out
);
  logic rx_ok;
  logic sfd_found;

  assign rx_ok = rx_valid & ~tx_busy;

  sfd_hunt #(.W(PAT_BITS), .PAT(PAT_WORD)) u_hunt (
    .clk    (clk),
    .rst    (rst),
    .rx_ok  (rx_ok),
    .rx_bit (rx_bit),
    .found  (sfd_found)
  );

  delim_phase #(.HALF_BITS(HALF_BITS)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .rx_ok  (rx_ok),
    .found  (sfd_found),
    .strobe (delim_strobe)
  );

  ser_fwd u_fwd (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit),
    .ser_out  (ser_out)
  );

  // R2
  fwd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ser_out == $past(rx_bit & rx_valid));

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !delim_strobe);

  // R7
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !delim_strobe);
endmodule

// File: tb/sfd_delim_gen_test.sv
module sfd_delim_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic rx_bit = 1'b0;
  logic tx_busy = 1'b0;
  logic delim_strobe;
  logic ser_out;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  // bench model state
  logic [7:0] m_hist = 8'h00;
  bit         m_run = 1'b0;
  bit         m_str = 1'b0;
  int         m_ph  = 0;

  always #5 clk = ~clk;

  sfd_delim_gen uut (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_bit       (rx_bit),
    .tx_busy      (tx_busy),
    .delim_strobe (delim_strobe),
    .ser_out      (ser_out)
  );

  task automatic step(input logic v, input logic b, input logic t, input string tag);
    logic exp_ser;
    @(negedge clk);
    rx_valid = v; rx_bit = b; tx_busy = t;
    if (!v || t) begin
      m_run = 1'b0; m_str = 1'b0; m_ph = 0; m_hist = 8'h00;
    end else begin
      if (!m_run) begin
        if (m_hist == 8'b1010_1011) begin
          m_run = 1'b1; m_ph = 0; m_str = 1'b1;
        end
      end else if (m_ph == 3) begin
        m_ph = 0; m_str = !m_str;
      end else begin
        m_ph++;
      end
      m_hist = {m_hist[6:0], b};
    end
    exp_ser = v & b;
    @(posedge clk);
    #1;
    n_vec++;
    if (delim_strobe !== m_str) begin
      n_bad++;
      $display("FAIL %s: delim_strobe actual %b expected %b at %0t", tag, delim_strobe, m_str, $time);
    end
    n_vec++;
    if (ser_out !== exp_ser) begin
      n_bad++;
      $display("FAIL R2: ser_out actual %b expected %b at %0t", ser_out, exp_ser, $time);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input string tag);
    for (int i = 0; i < 8; i++) step(1'b1, d[i], 1'b0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, "R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (delim_strobe !== 1'b0 || ser_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: strobe/ser actual %b%b expected 00", delim_strobe, ser_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R3 / R4: sweep preamble length and payload length
    for (int p = 0; p < 5; p++) begin
      for (int n = 1; n < 7; n++) begin
        for (int k = 0; k < p; k++) send_byte(8'h55, "R3");
        send_byte(8'hD5, "R3");
        for (int k = 0; k < n; k++) send_byte(8'((p * 37 + n * 11 + k * 91) & 8'hFF), "R4");
        idle(2);
      end
    end

    // R8: delimiter and preamble bytes inside the data
    send_byte(8'h55, "R8");
    send_byte(8'hD5, "R8");
    for (int k = 0; k < 4; k++) send_byte((k % 2) ? 8'hD5 : 8'h55, "R8");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R8");
    idle(2);

    // R5: preamble only, then each single-bit corruption of the delimiter
    for (int k = 0; k < 4; k++) send_byte(8'h55, "R5");
    idle(2);
    for (int f = 0; f < 8; f++) begin
      send_byte(8'h55, "R5");
      send_byte(8'hD5 ^ (8'h01 << f), "R5");
      for (int k = 0; k < 3; k++) send_byte(8'h00, "R5");
      idle(2);
    end

    // R6: valid drop in the middle of data, then data without a new delimiter
    send_byte(8'h55, "R6");
    send_byte(8'hD5, "R6");
    send_byte(8'h3C, "R6");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R6");
    idle(1);
    for (int k = 0; k < 4; k++) send_byte(8'hA7, "R6");
    idle(1);
    // R6: half a delimiter, drop, other half must not match
    for (int i = 0; i < 4; i++) step(1'b1, i[0] ? 1'b0 : 1'b1, 1'b0, "R6");
    idle(1);
    for (int i = 0; i < 4; i++) step(1'b1, (i == 1) ? 1'b0 : 1'b1, 1'b0, "R6");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, "R6");
    idle(2);

    // R7: transmit during data and across the delimiter
    send_byte(8'h55, "R7");
    send_byte(8'hD5, "R7");
    send_byte(8'h96, "R7");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, "R7");
    for (int k = 0; k < 3; k++) send_byte(8'h0F, "R7");
    send_byte(8'h55, "R7");
    for (int i = 0; i < 6; i++) step(1'b1, i[0] ? 1'b0 : 1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    for (int k = 0; k < 3; k++) send_byte(8'h00, "R7");
    // recovery after transmit ends
    send_byte(8'hD5, "R7");
    send_byte(8'h5A, "R7");
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule